// File: doc/BRIEF.md
# Bidirectional GPIO port controller

An eight-pin general-purpose I/O port. Each pin has a direction bit, a bit in an output data latch, and a synchronized input. Software reaches the port through three memory-mapped registers, using a 2-bit address and separate read and write strobes. The port register returns the pin levels as seen through a two-flop synchronizer. The latch register returns the value held in the output latch. The direction register returns the direction bits. Because a latch read never returns pin levels, read-modify-write on the latch is safe even when some pins are inputs or are held by an external load.

The pins can be handed to one of two other owners. While the bus-disable input is low, the port is the low byte of a multiplexed external address/data bus: that bus drives the pin data and the pin enables, and it sees the raw pin levels. While the bus is disabled and the slave-mode input is high, the pins belong to parallel slave port logic outside this block. That logic supplies the output data and the enable, and it receives the synchronized pin levels. The GPIO registers keep their contents through either handover and take back the pins when the port returns to GPIO mode.

Top module: `gpio_port8`

## Requirements
- R1: After reset, every direction bit is 1, the output latch is 0 and, in GPIO mode, every `pin_oe` bit is 0.
- R2: In GPIO mode (`bus_disable`=1, `slave_mode`=0), `pin_oe[i]` is the inverse of direction bit i and `pin_out` equals the output latch.
- R3: A write strobe to address 0 (port) or address 1 (latch) loads `reg_wdata` into the output latch at the next clock edge.
- R4: A read at address 1 returns the output latch contents, whatever the pin levels are.
- R5: A read at address 0 returns `pin_in` as it was two clock edges earlier, through a two-flop synchronizer that resets to 0.
- R6: A write at address 2 loads the direction bits at the next clock edge, and a read at address 2 returns them. A bit value of 1 means input and 0 means output.
- R7: While `bus_disable`=0, `pin_out` equals `bus_ad_out`, every `pin_oe` bit equals `bus_ad_oe`, and `bus_ad_in` equals `pin_in` with no delay. This holds whatever `slave_mode` is.
- R8: While `bus_disable`=1 and `slave_mode`=1, `pin_out` equals `slave_dout`, every `pin_oe` bit equals `slave_oe`, and `slave_din` carries the synchronized pin levels.
- R9: `reg_rdata` is 0 while `reg_rd` is low. Address 3 reads as 0, and a write to address 3 changes neither the latch nor the direction bits.
- R10: Each pin's direction is independent. With direction 0xCF, `pin_oe` is 0x30 and only bits 5:4 carry latch data.
- R11: A register write made while another owner holds the pins takes effect at the next edge, as it would in GPIO mode, and appears on the pins when GPIO mode returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 port, 1 latch, 2 direction, 3 unused |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, zero when not reading |
| bus_disable | input | 1 | 1 releases the pins from the external bus |
| slave_mode | input | 1 | 1 hands the pins to the slave port logic |
| bus_ad_out | input | 8 | Address/data driven by the external bus |
| bus_ad_oe | input | 1 | External bus drive enable |
| bus_ad_in | output | 8 | Raw pin levels for the external bus |
| slave_dout | input | 8 | Data driven by the slave port logic |
| slave_oe | input | 1 | Slave port drive enable |
| slave_din | output | 8 | Synchronized pin levels for the slave port |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Pin output data |
| pin_oe | output | 8 | Per-pin drive enable, 1 drives |

## Verification
The assertions assume that the strobes, address and mode inputs are stable around each rising edge. They also assume that `pin_in` is sampled only through the synchronizer, so the two-edge latency holds from the third active edge after reset. The bench changes every input one time unit after a rising edge and samples at the falling edge. It drives pin levels from an LFSR so that they seldom match the latch. It changes the ownership inputs only between register accesses, which keeps each ownership interval long enough for its mapping to be compared on every clock.

// File: rtl/gpio_port8.sv
module gpio_port8 #(
  parameter int WIDTH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [WIDTH-1:0] reg_wdata,
  output logic [WIDTH-1:0] reg_rdata,
  input  logic             bus_disable,
  input  logic             slave_mode,
  input  logic [WIDTH-1:0] bus_ad_out,
  input  logic             bus_ad_oe,
  output logic [WIDTH-1:0] bus_ad_in,
  input  logic [WIDTH-1:0] slave_dout,
  input  logic             slave_oe,
  output logic [WIDTH-1:0] slave_din,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);
  localparam logic [1:0] A_PORT = 2'd0;
  localparam logic [1:0] A_LAT  = 2'd1;
  localparam logic [1:0] A_DIR  = 2'd2;

  logic [WIDTH-1:0] dir_q, lat_q, pin_sync;
  logic [SYNC_STAGES-1:0][WIDTH-1:0] sync_q;

  wire lat_we = reg_wr && (reg_addr == A_PORT || reg_addr == A_LAT);
  wire dir_we = reg_wr && (reg_addr == A_DIR);
  wire own_bus   = !bus_disable;
  wire own_slave = bus_disable && slave_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
      lat_q <= '0;
    end else begin
      if (dir_we) dir_q <= reg_wdata;
      if (lat_we) lat_q <= reg_wdata;
    end
  end

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[s] <= '0;
        else if (s == 0) sync_q[s] <= pin_in;
        else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign pin_sync  = sync_q[SYNC_STAGES-1];
  assign slave_din = pin_sync;
  assign bus_ad_in = pin_in;

  always_comb begin
    if (own_bus) begin
      pin_out = bus_ad_out;
      pin_oe  = {WIDTH{bus_ad_oe}};
    end else if (own_slave) begin
      pin_out = slave_dout;
      pin_oe  = {WIDTH{slave_oe}};
    end else begin
      pin_out = lat_q;
      pin_oe  = ~dir_q;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        A_PORT:  reg_rdata = pin_sync;
        A_LAT:   reg_rdata = lat_q;
        A_DIR:   reg_rdata = dir_q;
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

module gpio_port8_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       reg_addr,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [WIDTH-1:0] reg_wdata,
  input logic [WIDTH-1:0] reg_rdata,
  input logic             bus_disable,
  input logic             slave_mode,
  input logic [WIDTH-1:0] bus_ad_out,
  input logic             bus_ad_oe,
  input logic [WIDTH-1:0] slave_din,
  input logic [WIDTH-1:0] pin_in,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_oe,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] lat_q
);
  logic [1:0] live_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_cnt <= '0;
    else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dir_q == '1 && lat_q == '0));

  assert_dir_to_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2) |=>
      (!(bus_disable && !slave_mode) || pin_oe == ~$past(reg_wdata)));

  assert_latch_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr[1] == 1'b0) |=> lat_q == $past(reg_wdata));

  assert_sync_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cnt >= 2'd2) |-> slave_din == $past(pin_in, 2));

  assert_bus_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_disable |-> (pin_out == bus_ad_out && pin_oe == {WIDTH{bus_ad_oe}}));

  assert_idle_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> reg_rdata == '0);

  assert_addr3_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd3) |=> ($stable(dir_q) && $stable(lat_q)));
endmodule

bind gpio_port8 gpio_port8_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .bus_disable(bus_disable), .slave_mode(slave_mode),
  .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .slave_din(slave_din),
  .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
  .dir_q(dir_q), .lat_q(lat_q)
);

// File: tb/gpio_port8_tb.sv
module gpio_port8_tb_top;
  logic clk = 0, rst_n = 0;
  logic [1:0] reg_addr = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic bus_disable = 1, slave_mode = 0;
  logic [7:0] bus_ad_out = 0, bus_ad_in, slave_dout = 0, slave_din;
  logic bus_ad_oe = 0, slave_oe = 0;
  logic [7:0] pin_in = 0, pin_out, pin_oe;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_port8 dut_i (.*);

  // behavioural reference
  logic [7:0] m_dir, m_lat;
  logic [7:0] hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = 8'hFF; m_lat = 8'h00; hist.delete();
    end else begin
      if (reg_wr && reg_addr == 2'd2) m_dir = reg_wdata;
      if (reg_wr && reg_addr < 2'd2) m_lat = reg_wdata;
      hist.push_front(pin_in);
      if (hist.size() > 2) void'(hist.pop_back());
    end
  end

  function automatic logic [7:0] m_sync();
    return (hist.size() < 2) ? 8'h00 : hist[1];
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    logic [7:0] e_out, e_oe, e_rd;
    string t;
    if (!bus_disable) begin e_out = bus_ad_out; e_oe = {8{bus_ad_oe}}; t = "R7"; end
    else if (slave_mode) begin e_out = slave_dout; e_oe = {8{slave_oe}}; t = "R8"; end
    else begin e_out = m_lat; e_oe = ~m_dir; t = "R2"; end
    check({t, " pin_out"}, pin_out, e_out);
    check({t, " pin_oe"}, pin_oe, e_oe);
    check("R7 bus_ad_in", bus_ad_in, pin_in);
    check("R8 slave_din", slave_din, m_sync());
    if (!reg_rd) begin e_rd = 0; t = "R9"; end
    else case (reg_addr)
      2'd0: begin e_rd = m_sync(); t = "R5"; end
      2'd1: begin e_rd = m_lat; t = "R4"; end
      2'd2: begin e_rd = m_dir; t = "R6"; end
      default: begin e_rd = 0; t = "R9"; end
    endcase
    check({t, " rdata"}, reg_rdata, e_rd);
  end

  logic [7:0] lfsr = 8'hA5;
  task automatic step();
    @(posedge clk); #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    pin_in = lfsr;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_addr = a; reg_wr = 1; reg_rd = 0; reg_wdata = d;
    step();
    reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, string tag, logic [7:0] exp);
    reg_addr = a; reg_rd = 1;
    @(negedge clk); #1;
    check(tag, reg_rdata, exp);
    step();
    reg_rd = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    check("R1 reset pin_oe", pin_oe, 8'h00);
    rd(2'd2, "R1 reset dir", 8'hFF);
    rd(2'd1, "R1 reset latch", 8'h00);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h5A);
    rd(2'd1, "R3 port write to latch", 8'h5A);
    wr(2'd1, 8'hC3);
    rd(2'd1, "R3 latch write", 8'hC3);
    check("R2 pin_out", pin_out, 8'hC3);
    wr(2'd2, 8'hCF);
    @(negedge clk); #1;
    check("R10 mixed oe", pin_oe, 8'h30);
    check("R10 mixed data", pin_out & pin_oe, 8'h00);
    wr(2'd1, 8'hFF);
    @(negedge clk); #1;
    check("R10 mixed data", pin_out & pin_oe, 8'h30);
    rd(2'd2, "R6 dir read", 8'hCF);
    for (int i = 0; i < 20; i++) begin
      reg_addr = 2'd0; reg_rd = 1; step();
    end
    reg_rd = 0;
    wr(2'd3, 8'h12);
    rd(2'd3, "R9 addr3 read", 8'h00);
    rd(2'd1, "R9 addr3 no latch effect", 8'hFF);
    rd(2'd2, "R9 addr3 no dir effect", 8'hCF);
    bus_disable = 0; bus_ad_out = 8'h3C; bus_ad_oe = 1; step();
    for (int i = 0; i < 6; i++) begin
      bus_ad_out = lfsr ^ 8'h0F; bus_ad_oe = i[0]; slave_mode = i[1]; step();
    end
    wr(2'd1, 8'h96);
    bus_disable = 1; slave_mode = 1; slave_oe = 1; slave_dout = 8'hE1; step();
    for (int i = 0; i < 8; i++) begin
      slave_dout = ~lfsr; slave_oe = i[1]; step();
    end
    wr(2'd2, 8'h0F);
    slave_mode = 0; step();
    @(negedge clk); #1;
    check("R11 latch after handover", pin_out, 8'h96);
    check("R11 dir after handover", pin_oe, 8'hF0);
    for (int i = 0; i < 10; i++) begin
      reg_addr = 2'(i % 4); reg_rd = 1; step();
    end
    reg_rd = 0;
    rst_n = 0; step();
    @(negedge clk); #1;
    rst_n = 1;
    @(negedge clk); #1;
    check("R1 second reset oe", pin_oe, 8'h00);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule